// File: doc/BRIEF.md
# ECC Error Capture Register Bank

This block sits beside a DRAM controller's ECC checker and keeps a record of memory error events. The checker sends single-cycle pulses for five sources: correctable error, uncorrectable error, refresh timeout, non-DRAM lock error and thermal event. With each pulse it also sends the error details: a 128-byte cache-line address, a channel bit, address bit 32, an 8-bit syndrome and a destination code. The block turns the pulses into sticky status bits. It captures the details of the first ECC error, and a later uncorrectable error may take over a log that holds only a correctable one.

Software reaches the bank through a flat register port. The port has a 3-bit word offset and a write strobe, and read data is combinational. The status bits are cleared by writing 1 to them. Three enable registers send the status bits to three reporting outputs: a system-error line, a management-interrupt line and a control-interrupt line. Each output is a level that stays high until software clears the status bit that caused it. If more than one path is enabled for the same source, only one path reports it, so the three paths stay mutually exclusive per source.

Top module: `ecc_err_log`

## Requirements
- R1: After reset every register reads zero and the three reporting outputs are low.
- R2: The status word is at offset 0. Its bits are: bit 0 correctable, bit 1 uncorrectable, bit 8 refresh timeout, bit 9 lock error, bit 11 thermal. A pulse sets its bit, visible one cycle after the pulse. All other bits read zero.
- R3: The address pointer is at offset 1. It reads the cache-line address in bits 31:7, zero in bits 6:1 and the channel in bit 0. Offset 2 reads address bit 32 in bit 0 and zero in bits 7:1.
- R4: The syndrome is at offset 3 and the destination at offset 4. When both ECC status bits are clear, the first correctable or uncorrectable pulse loads the address, extended bit, syndrome and destination.
- R5: An uncorrectable pulse that arrives while the correctable bit is set and the uncorrectable bit is clear replaces all logged details. Afterwards both bits read set.
- R6: A correctable pulse never changes the log while either ECC bit is set. An uncorrectable pulse never changes the log while the uncorrectable bit is set.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a pulse for a bit comes in the same cycle as the write that clears it, the bit stays set.
- R8: The system-error enable is at offset 5 and keeps bits 0, 1, 8, 9 and 11. The management enable (offset 6) and the control enable (offset 7) keep only bits 1:0. All other bits read zero.
- R9: Each reporting output is high while some status bit and its effective enable are both set. It rises one cycle after the pulse and falls one cycle after the clearing write.
- R10: When several paths enable the same source, only one of them reports it. The system-error path wins over the management path, and the management path wins over the control path.
- R11: Writes to offsets 1 to 4 are ignored, and the logged values keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceEvt | input | 1 | Correctable error pulse |
| ueEvt | input | 1 | Uncorrectable error pulse |
| rfshEvt | input | 1 | Refresh timeout pulse |
| lockEvt | input | 1 | Non-DRAM lock error pulse |
| thermEvt | input | 1 | Thermal event pulse |
| evtLine | input | 25 | Cache-line address (address bits 31:7) of the error |
| evtChan | input | 1 | Channel of the error |
| evtAddrHi | input | 1 | Address bit 32 of the error |
| evtSyn | input | 8 | ECC syndrome |
| evtDest | input | 8 | Destination code (0 = processor read) |
| regAddr | input | 3 | Register word offset |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr |
| serrOut | output | 1 | System-error report level |
| smiOut | output | 1 | Management-interrupt report level |
| sciOut | output | 1 | Control-interrupt report level |

## Verification
A wrong load decision shows up at offsets 1 to 4 on the first read after the pulse. The log would then hold the details of a correctable error where the uncorrectable error's should be, or the reverse. That mistake stays visible until both bits are cleared and a new error arrives. A faulty status bit or enable shows on the reporting outputs one cycle after the pulse or the clearing write. A missed priority shows up as two outputs high for a single source.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int DW       = 32;
  localparam int AW       = 3;
  localparam int SW       = 16;
  localparam int SYN_W    = 8;
  localparam int DEST_W   = 8;
  localparam int XW       = 8;
  localparam int LINE_LSB = 7;
  localparam int LINE_W   = DW - LINE_LSB;
  localparam int SHORT_W  = 2;

  localparam int B_CE    = 0;
  localparam int B_UE    = 1;
  localparam int B_RFSH  = 8;
  localparam int B_LOCK  = 9;
  localparam int B_THERM = 11;

  localparam logic [SW-1:0] STAT_MASK = (SW'(1) << B_CE) | (SW'(1) << B_UE) |
                                        (SW'(1) << B_RFSH) | (SW'(1) << B_LOCK) |
                                        (SW'(1) << B_THERM);

  localparam logic [AW-1:0] OFF_STAT = 3'd0;
  localparam logic [AW-1:0] OFF_EAP  = 3'd1;
  localparam logic [AW-1:0] OFF_XADR = 3'd2;
  localparam logic [AW-1:0] OFF_SYN  = 3'd3;
  localparam logic [AW-1:0] OFF_DEST = 3'd4;
  localparam logic [AW-1:0] OFF_SERR = 3'd5;
  localparam logic [AW-1:0] OFF_SMI  = 3'd6;
  localparam logic [AW-1:0] OFF_SCI  = 3'd7;

  typedef struct packed {
    logic            loadLog;
    logic [SW-1:0]   setBits;
    logic [SW-1:0]   clrBits;
    logic            wrSerr;
    logic            wrSmi;
    logic            wrSci;
  } ctlStrobe_t;

  typedef struct packed {
    logic [LINE_W-1:0] line;
    logic              chan;
    logic              addrHi;
    logic [SYN_W-1:0]  syn;
    logic [DEST_W-1:0] dest;
  } errInfo_t;
endpackage

// File: rtl/ecc_log_ctrl.sv
module ecc_log_ctrl
  import ecc_log_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          ceEvt,
  input  logic          ueEvt,
  input  logic          rfshEvt,
  input  logic          lockEvt,
  input  logic          thermEvt,
  input  logic [AW-1:0] regAddr,
  input  logic          regWrEn,
  input  logic [SW-1:0] regWrLo,
  input  logic [SW-1:0] curStat,
  output ctlStrobe_t    stb
);
  logic ceHeld, ueHeld, firstErr, ueOverCe;

  assign ceHeld   = curStat[B_CE];
  assign ueHeld   = curStat[B_UE];
  assign firstErr = (ceEvt | ueEvt) & ~ceHeld & ~ueHeld;
  assign ueOverCe = ueEvt & ceHeld & ~ueHeld;

  always_comb begin
    stb = '0;
    stb.loadLog         = firstErr | ueOverCe;
    stb.setBits[B_CE]    = ceEvt;
    stb.setBits[B_UE]    = ueEvt;
    stb.setBits[B_RFSH]  = rfshEvt;
    stb.setBits[B_LOCK]  = lockEvt;
    stb.setBits[B_THERM] = thermEvt;
    if (regWrEn && regAddr == OFF_STAT) stb.clrBits = regWrLo & STAT_MASK;
    stb.wrSerr = regWrEn && regAddr == OFF_SERR;
    stb.wrSmi  = regWrEn && regAddr == OFF_SMI;
    stb.wrSci  = regWrEn && regAddr == OFF_SCI;
  end

  // R6: once the uncorrectable bit is held, no pulse reloads the log
  a_r6_no_reload_after_ue: assert property (@(posedge clk) disable iff (!rstN)
    curStat[B_UE] |-> !stb.loadLog);
endmodule

// File: rtl/ecc_log_dp.sv
module ecc_log_dp
  import ecc_log_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    stb,
  input  errInfo_t      info,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] regWrData,
  output logic [SW-1:0] curStat,
  output logic [DW-1:0] regRdData,
  output logic          serrOut,
  output logic          smiOut,
  output logic          sciOut
);
  logic [SW-1:0]      statQ, serrQ;
  logic [SHORT_W-1:0] smiQ, sciQ;
  errInfo_t           logQ;
  logic [SW-1:0]      effSmi, effSci;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statQ <= '0;
      logQ  <= '0;
      serrQ <= '0;
      smiQ  <= '0;
      sciQ  <= '0;
    end else begin
      statQ <= ((statQ & ~stb.clrBits) | stb.setBits) & STAT_MASK;
      if (stb.loadLog) logQ <= info;
      if (stb.wrSerr) serrQ <= regWrData[SW-1:0] & STAT_MASK;
      if (stb.wrSmi)  smiQ  <= regWrData[SHORT_W-1:0];
      if (stb.wrSci)  sciQ  <= regWrData[SHORT_W-1:0];
    end
  end

  assign curStat = statQ;

  // per-source priority: system error, then management, then control
  always_comb begin
    effSmi = '0;
    effSci = '0;
    effSmi[SHORT_W-1:0] = smiQ & ~serrQ[SHORT_W-1:0];
    effSci[SHORT_W-1:0] = sciQ & ~serrQ[SHORT_W-1:0] & ~smiQ;
  end

  assign serrOut = |(statQ & serrQ);
  assign smiOut  = |(statQ & effSmi);
  assign sciOut  = |(statQ & effSci);

  always_comb begin
    regRdData = '0;
    case (regAddr)
      OFF_STAT: regRdData[SW-1:0] = statQ;
      OFF_EAP:  regRdData = {logQ.line, {(LINE_LSB-1){1'b0}}, logQ.chan};
      OFF_XADR: regRdData[0] = logQ.addrHi;
      OFF_SYN:  regRdData[SYN_W-1:0] = logQ.syn;
      OFF_DEST: regRdData[DEST_W-1:0] = logQ.dest;
      OFF_SERR: regRdData[SW-1:0] = serrQ;
      OFF_SMI:  regRdData[SHORT_W-1:0] = smiQ;
      default:  regRdData[SHORT_W-1:0] = sciQ;
    endcase
  end

  // R5: uncorrectable over pending correctable takes over the log
  a_r5_ue_overwrite: assert property (@(posedge clk) disable iff (!rstN)
    stb.setBits[B_UE] && statQ[B_CE] && !statQ[B_UE] |=>
      logQ.syn == $past(info.syn) && logQ.line == $past(info.line) && statQ[B_CE] && statQ[B_UE]);
  // R6: correctable pulse with a held ECC bit leaves the log alone
  a_r6_ce_held: assert property (@(posedge clk) disable iff (!rstN)
    stb.setBits[B_CE] && !stb.setBits[B_UE] && (statQ[B_CE] || statQ[B_UE]) |=> $stable(logQ));
  // R7: the event wins a collision with its own clear
  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    stb.setBits[B_CE] |=> statQ[B_CE]);
  // R7: no set and no clear keeps status
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    stb.setBits == '0 && stb.clrBits == '0 |=> $stable(statQ));
  // R9: enabled uncorrectable pulse raises the system-error line next cycle
  a_r9_ue_report: assert property (@(posedge clk) disable iff (!rstN)
    stb.setBits[B_UE] && serrQ[B_UE] && !stb.wrSerr |=> serrOut);
  // R10: a source owned by the system-error path reaches no other line
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    statQ == (SW'(1) << B_CE) && serrQ[B_CE] |-> !smiOut && !sciOut);
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceEvt,
  input  logic              ueEvt,
  input  logic              rfshEvt,
  input  logic              lockEvt,
  input  logic              thermEvt,
  input  logic [LINE_W-1:0] evtLine,
  input  logic              evtChan,
  input  logic              evtAddrHi,
  input  logic [SYN_W-1:0]  evtSyn,
  input  logic [DEST_W-1:0] evtDest,
  input  logic [AW-1:0]     regAddr,
  input  logic              regWrEn,
  input  logic [DW-1:0]     regWrData,
  output logic [DW-1:0]     regRdData,
  output logic              serrOut,
  output logic              smiOut,
  output logic              sciOut
);
  ctlStrobe_t    stb;
  errInfo_t      info;
  logic [SW-1:0] curStat;

  assign info = '{line: evtLine, chan: evtChan, addrHi: evtAddrHi, syn: evtSyn, dest: evtDest};

  ecc_log_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .ceEvt(ceEvt), .ueEvt(ueEvt), .rfshEvt(rfshEvt),
    .lockEvt(lockEvt), .thermEvt(thermEvt), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrLo(regWrData[SW-1:0]), .curStat(curStat), .stb(stb)
  );

  ecc_log_dp uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .info(info), .regAddr(regAddr),
    .regWrData(regWrData), .curStat(curStat), .regRdData(regRdData),
    .serrOut(serrOut), .smiOut(smiOut), .sciOut(sciOut)
  );
endmodule

// File: tb/tb_ecc_err_log.sv
module tb_ecc_err_log;
  logic clk = 1'b0, rstN = 1'b0;
  logic ceEvt = 0, ueEvt = 0, rfshEvt = 0, lockEvt = 0, thermEvt = 0;
  logic [24:0] evtLine = '0;
  logic evtChan = 0, evtAddrHi = 0;
  logic [7:0] evtSyn = '0, evtDest = '0;
  logic [2:0] regAddr = '0;
  logic regWrEn = 0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic serrOut, smiOut, sciOut;

  int checks = 0, failures = 0;
  logic [15:0] mStat, mSerr;
  logic [1:0] mSmi, mSci;
  logic [24:0] mLine;
  logic mChan, mHi;
  logic [7:0] mSyn, mDest;
  localparam logic [15:0] MASK = 16'h0B03;

  always #4 clk = ~clk;

  ecc_err_log dut (.*);

  initial begin
    #1600000;
    failures++;
    $display("FAIL watchdog expired: got hang, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] expRead(logic [2:0] a);
    case (a)
      3'd0: return {16'h0, mStat};
      3'd1: return {mLine, 6'b0, mChan};
      3'd2: return {31'b0, mHi};
      3'd3: return {24'b0, mSyn};
      3'd4: return {24'b0, mDest};
      3'd5: return {16'h0, mSerr};
      3'd6: return {30'b0, mSmi};
      default: return {30'b0, mSci};
    endcase
  endfunction

  function automatic logic [2:0] expOuts();
    logic [15:0] eSmi, eSci;
    eSmi = {14'b0, mSmi & ~mSerr[1:0]};
    eSci = {14'b0, mSci & ~mSerr[1:0] & ~mSmi};
    return {|(mStat & mSerr), |(mStat & eSmi), |(mStat & eSci)};
  endfunction

  // reference update from the requirements, using pre-edge state
  task automatic modelStep();
    logic ld;
    logic [15:0] setB, clrB;
    ld = (ceEvt | ueEvt) && ((mStat[1:0] == 2'b00) || (ueEvt && mStat[0] && !mStat[1]));
    setB = {4'b0, thermEvt, 1'b0, lockEvt, rfshEvt, 6'b0, ueEvt, ceEvt};
    clrB = (regWrEn && regAddr == 3'd0) ? (regWrData[15:0] & MASK) : 16'h0;
    if (ld) begin
      mLine = evtLine; mChan = evtChan; mHi = evtAddrHi; mSyn = evtSyn; mDest = evtDest;
    end
    if (regWrEn && regAddr == 3'd5) mSerr = regWrData[15:0] & MASK;
    if (regWrEn && regAddr == 3'd6) mSmi = regWrData[1:0];
    if (regWrEn && regAddr == 3'd7) mSci = regWrData[1:0];
    mStat = (mStat & ~clrB) | setB;
  endtask

  // one clock with the current inputs, then inputs idle
  task automatic cycle();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    {ceEvt, ueEvt, rfshEvt, lockEvt, thermEvt, regWrEn} = '0;
  endtask

  task automatic checkAll(string req);
    for (int a = 0; a < 8; a++) begin
      regAddr = 3'(a);
      #1;
      check(req, regRdData, expRead(3'(a)));
    end
    check(req, {29'b0, serrOut, smiOut, sciOut}, {29'b0, expOuts()});
  endtask

  task automatic setInfo(logic [24:0] l, logic c, logic h, logic [7:0] s, logic [7:0] d);
    evtLine = l; evtChan = c; evtAddrHi = h; evtSyn = s; evtDest = d;
  endtask

  task automatic regWrite(logic [2:0] a, logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1;
  endtask

  initial begin
    {mStat, mSerr, mSmi, mSci, mLine, mChan, mHi, mSyn, mDest} = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    checkAll("R1 reset");

    // R4 first correctable loads log; R3 formats
    setInfo(25'h1ABCDEF, 1, 1, 8'h5A, 8'h00); ceEvt = 1; cycle();
    checkAll("R4 R3 first CE load");
    // R5 UE over pending CE
    setInfo(25'h0123456, 0, 0, 8'hC3, 8'h07); ueEvt = 1; cycle();
    checkAll("R5 UE overwrite");
    // R6 CE then UE with UE held: log unchanged
    setInfo(25'h1555555, 1, 1, 8'h11, 8'h22); ceEvt = 1; cycle();
    ueEvt = 1; cycle();
    checkAll("R6 log held");
    // R11 writes to log registers ignored
    for (int a = 1; a < 5; a++) begin regWrite(3'(a), 32'hFFFF_FFFF); cycle(); end
    checkAll("R11 log read-only");
    // R7 write 0 no effect, W1C, collision
    regWrite(3'd0, 32'h0); cycle();
    checkAll("R7 zero write");
    regWrite(3'd0, 32'h3); ceEvt = 1; cycle();
    checkAll("R7 event wins");
    regWrite(3'd0, 32'hFFFF); cycle();
    checkAll("R7 clear all");
    // R2 other sources, R8 masks
    rfshEvt = 1; lockEvt = 1; thermEvt = 1; cycle();
    checkAll("R2 other sources");
    regWrite(3'd5, 32'hFFFF_FFFF); cycle();
    regWrite(3'd6, 32'hFFFF_FFFF); cycle();
    regWrite(3'd7, 32'hFFFF_FFFF); cycle();
    checkAll("R8 enable masks");
    // R10 priority: SERR owns CE, SMI owns UE, SCI gets nothing
    regWrite(3'd5, 32'h0001); cycle();
    regWrite(3'd0, 32'hFFFF); cycle();
    ueEvt = 1; cycle();
    checkAll("R10 R9 UE to management");
    check("R10 control line quiet", {31'b0, sciOut}, 32'h0);
    regWrite(3'd0, 32'h2); cycle();
    checkAll("R9 level falls on clear");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      ceEvt = r[0] & r[1]; ueEvt = r[2] & r[3] & r[4];
      rfshEvt = r[5] & r[6] & r[7]; lockEvt = r[8] & r[9] & r[10]; thermEvt = r[11] & r[12] & r[13];
      setInfo(25'($urandom), r[14], r[15], 8'($urandom), 8'($urandom));
      if (r[16] & r[17]) regWrite(3'($urandom_range(0, 7)), $urandom);
      cycle();
      checkAll("R2 R4 R5 R6 R7 R9 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial void'($urandom(32'd12345));
endmodule